// File: doc/BRIEF.md
# Sprite and Tile Layer Priority Mixer

This block composites one screen pixel per clock from four candidate sources: three tile layers and one sprite. Each source presents a colour value and a palette index. The sprite also carries a 2-bit depth field that decides where it sits among the tile layers. The mixer finds the frontmost source that is opaque and forms a colour-RAM address from it. That address is made of a source code, the source's palette index and its colour value, so every source reads its own region of colour RAM. When every source is transparent, a fixed background address is produced instead.

The tile layers are not stacked in index order. From front to back the depth order is:

1. sprite at depth 3
2. tile layer 0
3. sprite at depth 2
4. tile layer 2
5. sprite at depth 1
6. tile layer 1

A sprite at depth 0 is never drawn. The result is registered, so the block slots into a pixel pipeline with a latency of one clock. A valid flag travels alongside the pixel.

Top module: `pixPriorityMixer`

## Requirements
- R1: While `rstN` is low, and on the first clock after it, `outValid` is 0 and `pixAddr` is 0.
- R2: `outValid` equals the value `inValid` had at the previous rising clock edge.
- R3: When `inValid` is 0 at a rising edge, `pixAddr` keeps its previous value.
- R4: A source whose colour value is 0 is transparent. It never wins, whatever its palette index.
- R5: Among opaque sources, the winner is the frontmost one in this order: sprite at depth 3, layer 0, sprite at depth 2, layer 2, sprite at depth 1, layer 1.
- R6: A sprite with depth field 0 is never selected, even when its colour value is non-zero.
- R7: When no source is opaque, `pixAddr` = {3'd4, `BG_PAL`, `BG_COLOR`}. The defaults are `BG_PAL`=0 and `BG_COLOR`=0.
- R8: For a winning source, `pixAddr` = {source code, palette index, colour value}. The source code sits in bits [12:10], the palette index in bits [9:4] and the colour in bits [3:0]. The source codes are: sprite 0, layer 0 is 1, layer 1 is 2, layer 2 is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel set is valid |
| l0Col | input | 4 | Tile layer 0 colour value (0 = transparent) |
| l0Pal | input | 6 | Tile layer 0 palette index |
| l1Col | input | 4 | Tile layer 1 colour value |
| l1Pal | input | 6 | Tile layer 1 palette index |
| l2Col | input | 4 | Tile layer 2 colour value |
| l2Pal | input | 6 | Tile layer 2 palette index |
| sprCol | input | 4 | Sprite colour value |
| sprPal | input | 6 | Sprite palette index |
| sprPrio | input | 2 | Sprite depth field (0 = hidden) |
| outValid | output | 1 | Output address is valid |
| pixAddr | output | 13 | Colour-RAM address of the winning source |

## Verification
The assertions assume that `inValid` and every pixel field are known, never X, at each rising edge once reset is released. They also assume that `rstN` is driven low for at least one edge before any checking begins. The bench drives every input at the falling edge, from fully defined values. Its random patterns pick the colour values with a strong bias toward zero, so that transparent stacks and all six depth positions come up often. Directed cases then cover the all-transparent pixel, a hidden sprite, and each neighbouring pair in the depth order.

// File: rtl/mixPkg.sv
package mixPkg;
  localparam int SRC_W = 3;
  localparam logic [SRC_W-1:0] SRC_SPR = 3'd0;
  localparam logic [SRC_W-1:0] SRC_L0  = 3'd1;
  localparam logic [SRC_W-1:0] SRC_L1  = 3'd2;
  localparam logic [SRC_W-1:0] SRC_L2  = 3'd3;
  localparam logic [SRC_W-1:0] SRC_BG  = 3'd4;

  typedef struct packed {
    logic load;
    logic pickSpr;
    logic pickL0;
    logic pickL1;
    logic pickL2;
    logic pickBg;
  } mixStrobe_t;
endpackage

// File: rtl/mixCtrl.sv
module mixCtrl #(
  parameter int COL_W  = 4,
  parameter int PRIO_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [COL_W-1:0]        l0Col,
  input  logic [COL_W-1:0]        l1Col,
  input  logic [COL_W-1:0]        l2Col,
  input  logic [COL_W-1:0]        sprCol,
  input  logic [PRIO_W-1:0]       sprPrio,
  output mixPkg::mixStrobe_t      strobe
);
  import mixPkg::*;

  localparam int NDEPTH = 6;

  logic l0On, l1On, l2On, sprOn;
  logic [NDEPTH-1:0] slotOn;   // index 0 = frontmost slot
  logic [NDEPTH-1:0] slotWin;

  assign l0On  = (l0Col  != '0);
  assign l1On  = (l1Col  != '0);
  assign l2On  = (l2Col  != '0);
  assign sprOn = (sprCol != '0) && (sprPrio != '0);

  // front to back: spr3, L0, spr2, L2, spr1, L1
  always_comb begin
    slotOn[0] = sprOn && (sprPrio == PRIO_W'(3));
    slotOn[1] = l0On;
    slotOn[2] = sprOn && (sprPrio == PRIO_W'(2));
    slotOn[3] = l2On;
    slotOn[4] = sprOn && (sprPrio == PRIO_W'(1));
    slotOn[5] = l1On;
  end

  // the first opaque slot wins
  genvar gi;
  generate
    for (gi = 0; gi < NDEPTH; gi++) begin : g_win
      if (gi == 0) begin : g_first
        assign slotWin[gi] = slotOn[gi];
      end else begin : g_rest
        assign slotWin[gi] = slotOn[gi] && (slotOn[gi-1:0] == '0);
      end
    end
  endgenerate

  always_comb begin
    strobe.load    = inValid;
    strobe.pickSpr = slotWin[0] | slotWin[2] | slotWin[4];
    strobe.pickL0  = slotWin[1];
    strobe.pickL2  = slotWin[3];
    strobe.pickL1  = slotWin[5];
    strobe.pickBg  = (slotOn == '0);
  end

  // exactly one source is chosen for every valid pixel
  p_one_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> $countones({strobe.pickSpr, strobe.pickL0, strobe.pickL1,
                            strobe.pickL2, strobe.pickBg}) == 1);

  // a depth-0 sprite never gets picked
  p_hidden_sprite_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sprPrio == '0) |-> !strobe.pickSpr);
endmodule

// File: rtl/mixData.sv
module mixData #(
  parameter int COL_W  = 4,
  parameter int PAL_W  = 6,
  parameter int ADDR_W = mixPkg::SRC_W + PAL_W + COL_W,
  parameter logic [PAL_W-1:0] BG_PAL   = '0,
  parameter logic [COL_W-1:0] BG_COLOR = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  mixPkg::mixStrobe_t   strobe,
  input  logic [COL_W-1:0]     l0Col,
  input  logic [PAL_W-1:0]     l0Pal,
  input  logic [COL_W-1:0]     l1Col,
  input  logic [PAL_W-1:0]     l1Pal,
  input  logic [COL_W-1:0]     l2Col,
  input  logic [PAL_W-1:0]     l2Pal,
  input  logic [COL_W-1:0]     sprCol,
  input  logic [PAL_W-1:0]     sprPal,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    pixAddr
);
  import mixPkg::*;

  localparam int SRC_LSB = PAL_W + COL_W;
  localparam logic [ADDR_W-1:0] BG_ADDR = {SRC_BG, BG_PAL, BG_COLOR};

  logic [ADDR_W-1:0] nextAddr;

  // AND-OR mux on the one-hot pick strobes
  always_comb begin
    nextAddr = '0;
    if (strobe.pickSpr) nextAddr = nextAddr | {SRC_SPR, sprPal, sprCol};
    if (strobe.pickL0)  nextAddr = nextAddr | {SRC_L0,  l0Pal,  l0Col};
    if (strobe.pickL1)  nextAddr = nextAddr | {SRC_L1,  l1Pal,  l1Col};
    if (strobe.pickL2)  nextAddr = nextAddr | {SRC_L2,  l2Pal,  l2Col};
    if (strobe.pickBg)  nextAddr = nextAddr | BG_ADDR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      pixAddr  <= '0;
    end else begin
      outValid <= inValid;
      if (strobe.load) pixAddr <= nextAddr;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(pixAddr));

  p_background_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && l0Col == '0 && l1Col == '0 && l2Col == '0 && sprCol == '0)
      |=> (pixAddr == BG_ADDR));

  p_front_sprite_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sprCol != '0 && strobe.pickSpr && l0Col != '0)
      |=> (pixAddr[ADDR_W-1:SRC_LSB] == SRC_SPR));

  p_layer0_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && l0Col != '0 && sprCol == '0)
      |=> (pixAddr == {SRC_L0, $past(l0Pal), $past(l0Col)}));
endmodule

// File: rtl/pixPriorityMixer.sv
module pixPriorityMixer #(
  parameter int COL_W  = 4,
  parameter int PAL_W  = 6,
  parameter int PRIO_W = 2,
  parameter logic [PAL_W-1:0] BG_PAL   = '0,
  parameter logic [COL_W-1:0] BG_COLOR = '0,
  localparam int ADDR_W = mixPkg::SRC_W + PAL_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [COL_W-1:0]  l0Col,
  input  logic [PAL_W-1:0]  l0Pal,
  input  logic [COL_W-1:0]  l1Col,
  input  logic [PAL_W-1:0]  l1Pal,
  input  logic [COL_W-1:0]  l2Col,
  input  logic [PAL_W-1:0]  l2Pal,
  input  logic [COL_W-1:0]  sprCol,
  input  logic [PAL_W-1:0]  sprPal,
  input  logic [PRIO_W-1:0] sprPrio,
  output logic              outValid,
  output logic [ADDR_W-1:0] pixAddr
);
  mixPkg::mixStrobe_t strobe;

  mixCtrl #(.COL_W(COL_W), .PRIO_W(PRIO_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .l0Col(l0Col), .l1Col(l1Col), .l2Col(l2Col),
    .sprCol(sprCol), .sprPrio(sprPrio), .strobe(strobe)
  );

  mixData #(.COL_W(COL_W), .PAL_W(PAL_W), .ADDR_W(ADDR_W),
            .BG_PAL(BG_PAL), .BG_COLOR(BG_COLOR)) i_data (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe),
    .l0Col(l0Col), .l0Pal(l0Pal), .l1Col(l1Col), .l1Pal(l1Pal),
    .l2Col(l2Col), .l2Pal(l2Pal), .sprCol(sprCol), .sprPal(sprPal),
    .outValid(outValid), .pixAddr(pixAddr)
  );
endmodule

// File: tb/test_pixPriorityMixer.sv
`timescale 1ns/1ps
module test_pixPriorityMixer;
  localparam int COL_W = 4;
  localparam int PAL_W = 6;
  localparam int ADDR_W = 3 + PAL_W + COL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [COL_W-1:0] l0Col = '0, l1Col = '0, l2Col = '0, sprCol = '0;
  logic [PAL_W-1:0] l0Pal = '0, l1Pal = '0, l2Pal = '0, sprPal = '0;
  logic [1:0] sprPrio = '0;
  logic outValid;
  logic [ADDR_W-1:0] pixAddr;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  pixPriorityMixer i_pixPriorityMixer (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .l0Col(l0Col), .l0Pal(l0Pal), .l1Col(l1Col), .l1Pal(l1Pal),
    .l2Col(l2Col), .l2Pal(l2Pal), .sprCol(sprCol), .sprPal(sprPal),
    .sprPrio(sprPrio), .outValid(outValid), .pixAddr(pixAddr)
  );

  // Expected address from the depth order (R5..R8)
  function automatic logic [ADDR_W-1:0] refAddr();
    logic sOn;
    sOn = (sprCol != 0) && (sprPrio != 0);
    if (sOn && sprPrio == 2'd3) return {3'd0, sprPal, sprCol};
    if (l0Col != 0)             return {3'd1, l0Pal, l0Col};
    if (sOn && sprPrio == 2'd2) return {3'd0, sprPal, sprCol};
    if (l2Col != 0)             return {3'd3, l2Pal, l2Col};
    if (sOn && sprPrio == 2'd1) return {3'd0, sprPal, sprCol};
    if (l1Col != 0)             return {3'd2, l1Pal, l1Col};
    return {3'd4, 6'd0, 4'd0};
  endfunction

  task automatic checkVal(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pixel(input logic v,
                       input logic [3:0] c0, input logic [5:0] p0,
                       input logic [3:0] c1, input logic [5:0] p1,
                       input logic [3:0] c2, input logic [5:0] p2,
                       input logic [3:0] sc, input logic [5:0] sp,
                       input logic [1:0] pr, input string req);
    @(negedge clk);
    inValid = v; l0Col = c0; l0Pal = p0; l1Col = c1; l1Pal = p1;
    l2Col = c2; l2Pal = p2; sprCol = sc; sprPal = sp; sprPrio = pr;
    if (v) expAddr = refAddr();
    @(posedge clk); #1;
    checkVal({req, " valid (R2)"}, ADDR_W'(outValid), ADDR_W'(v));
    checkVal(req, pixAddr, expAddr);
  endtask

  function automatic logic [3:0] rndCol();
    if ($urandom_range(0, 99) < 55) return 4'd0;
    return 4'($urandom_range(1, 15));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    checkVal("R1 reset valid", ADDR_W'(outValid), '0);
    checkVal("R1 reset addr", pixAddr, '0);
    @(negedge clk); rstN = 1'b1;

    // R7 all transparent, palettes set but colours zero (R4)
    pixel(1, 0, 6'h3f, 0, 6'h15, 0, 6'h2a, 0, 6'h11, 2'd3, "R7 background");
    // R6 hidden sprite over layer 1
    pixel(1, 0, 0, 4'h5, 6'h07, 0, 0, 4'hf, 6'h22, 2'd0, "R6 hidden sprite");
    // R6 hidden sprite alone gives background
    pixel(1, 0, 0, 0, 0, 0, 0, 4'h9, 6'h22, 2'd0, "R6 hidden alone");
    // R5 neighbour pairs
    pixel(1, 4'h1, 6'h01, 4'h2, 6'h02, 4'h3, 6'h03, 4'h4, 6'h04, 2'd3, "R5 spr3 over L0");
    pixel(1, 4'h1, 6'h01, 4'h2, 6'h02, 4'h3, 6'h03, 4'h4, 6'h04, 2'd2, "R5 L0 over spr2");
    pixel(1, 0, 6'h01, 4'h2, 6'h02, 4'h3, 6'h03, 4'h4, 6'h04, 2'd2, "R5 spr2 over L2");
    pixel(1, 0, 6'h01, 4'h2, 6'h02, 4'h3, 6'h03, 4'h4, 6'h04, 2'd1, "R5 L2 over spr1");
    pixel(1, 0, 6'h01, 4'h2, 6'h02, 0, 6'h03, 4'h4, 6'h04, 2'd1, "R5 spr1 over L1");
    pixel(1, 0, 6'h01, 4'hc, 6'h2d, 0, 6'h03, 0, 6'h04, 2'd1, "R8 L1 field layout");
    // R4 transparent front layer with non-zero palette is skipped
    pixel(1, 0, 6'h3f, 0, 0, 4'h8, 6'h19, 0, 0, 2'd3, "R4 skip L0");
    // R3 hold while not valid
    pixel(0, 4'hf, 6'h3f, 4'hf, 6'h3f, 4'hf, 6'h3f, 4'hf, 6'h3f, 2'd3, "R3 hold");
    pixel(0, 4'h1, 6'h00, 0, 0, 0, 0, 0, 0, 2'd0, "R3 hold again");

    for (int i = 0; i < 3000; i++) begin
      pixel(($urandom_range(0, 9) != 0),
            rndCol(), 6'($urandom), rndCol(), 6'($urandom),
            rndCol(), 6'($urandom), rndCol(), 6'($urandom),
            2'($urandom), "R5 R8 random");
    end

    // R1 reset in the middle of traffic
    @(negedge clk); rstN = 1'b0; inValid = 1'b1; l0Col = 4'h3;
    @(posedge clk); #1;
    checkVal("R1 mid reset valid", ADDR_W'(outValid), '0);
    checkVal("R1 mid reset addr", pixAddr, '0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule